// File: doc/BRIEF.md
# Register-Mapped Byte Store Controller

A byte-wide nonvolatile-style data store that a processor reaches through four bus registers: a control register, an unlock register, a data register and an address register. A read is a single register operation. Software sets a start bit, and the addressed byte appears in the data register on the next clock. A write is deliberately hard to trigger. Software must enable writes, write a two-value key to the unlock register, and then set the write-start bit. The controller then runs a timed operation. It first erases the location to all ones and then programs the new byte.

The start bits can only be set by software, and hardware clears them. A running write therefore cannot be cancelled from the bus. Completion raises a sticky flag that drives the interrupt output. Reset comes in two kinds. A power-on reset clears every register. A warm reset keeps the data, address and select values, and it records a write it interrupted in a sticky error flag, so software can retry. The storage cells survive both kinds of reset.

Top module: `nvb_ctrl`

## Requirements
- R1: The control register sits at BASE+0, the unlock register at BASE+1, the data register at BASE+2 and the address register at BASE+3. A bus read returns its value on `bus_rdata` one clock after `bus_re`. The unlock register and any unmapped address always read 0x00.
- R2: The data and address registers read back the last value written to them.
- R3: Control register bits are: bit0 read-start, bit1 write-busy, bit2 write-enable, bit3 write-error, bit4 write-done, bit7 memory-select. Bits 5 and 6 read 0.
- R4: Writing control with bit0=1 loads the data register from the addressed byte on the next clock. Bit0 reads back as 0 afterwards. This happens only while memory-select is 0 and the address is below DEPTH.
- R5: A write starts only if the two previous bus writes put 0x55 and then 0xAA into the unlock register, and the control write has bit1=1 while write-enable is already 1. Any other sequence starts nothing and leaves the store unchanged.
- R6: Writing 0 to bit0 or bit1 has no effect. Bit1 reads 1 for exactly WRITE_CYCLES clocks after a write starts, and then hardware clears it.
- R7: While a write is in progress the target byte reads 0xFF. After completion it holds the byte that was in the data register when the write started.
- R8: Write completion sets bit4, and `irq` follows it. Writing 0 to bit4 clears it, and writing 1 has no effect.
- R9: Bus writes to the data and address registers are ignored while a write is in progress.
- R10: With memory-select at 1, or with address bits above the store index nonzero, read and write starts are ignored. The data register and the store stay unchanged.
- R11: A warm reset during a write ends the write, clears busy and write-enable, and sets bit3. The data, address and memory-select values are kept. Bit3 clears only when 0 is written to it.
- R12: A power-on reset clears all registers to 0x00, including the error flag, write-enable and memory-select. The store contents survive both kinds of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| bus_addr | input | BUS_AW | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Bus write strobe |
| bus_re | input | 1 | Bus read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Write-done interrupt |

## Verification
The bench builds the block with WRITE_CYCLES set to 5 and keeps the default depth of 64 and the default base address. A write then lasts a few clocks, so the bench can sweep the whole store with distinct computed bytes and read every location back. It can also sample the busy bit on every clock of a write, and it can land a read or a warm reset inside the erase phase. The same short window lets the bench run every broken unlock order, the out-of-range aliases and both kinds of reset cheaply.

// File: rtl/nvb_pkg.sv
package nvb_pkg;
  localparam int OFS_CTRL = 0;
  localparam int OFS_KEY  = 1;
  localparam int OFS_DATA = 2;
  localparam int OFS_ADDR = 3;

  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_WEN  = 2;
  localparam int CB_ERR  = 3;
  localparam int CB_DONE = 4;
  localparam int CB_SEL  = 7;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
  localparam logic [7:0] ERASED     = 8'hFF;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_HALF  = 2'd1,
    KS_ARMED = 2'd2
  } key_state_e;
endpackage

// File: rtl/nvb_keyseq.sv
module nvb_keyseq (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_any,
  input  logic       wr_key,
  input  logic [7:0] wdata,
  output logic       armed
);
  import nvb_pkg::*;

  key_state_e state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= KS_IDLE;
    end else if (wr_any) begin
      if (wr_key && wdata == KEY_FIRST)
        state_q <= KS_HALF;
      else if (wr_key && wdata == KEY_SECOND && state_q == KS_HALF)
        state_q <= KS_ARMED;
      else
        state_q <= KS_IDLE;
    end
  end

  assign armed = (state_q == KS_ARMED);
endmodule

// File: rtl/nvb_wtimer.sv
module nvb_wtimer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic erase,
  output logic prog
);
  localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (cnt_q == LAST) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign busy  = busy_q;
  assign erase = busy_q && (cnt_q == '0);
  assign prog  = busy_q && (cnt_q == LAST);
endmodule

// File: rtl/nvb_store.sv
module nvb_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      cells[waddr] <= wdata;
    if (re)
      rdata <= cells[raddr];
  end
endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl #(
  parameter int                BUS_AW       = 12,
  parameter logic [BUS_AW-1:0] BASE         = 12'hFA6,
  parameter int                DEPTH        = 64,
  parameter int                WRITE_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              por,
  input  logic              warm_rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  import nvb_pkg::*;

  localparam int IW = $clog2(DEPTH);
  localparam logic [BUS_AW-1:0] A_CTRL = BASE + BUS_AW'(OFS_CTRL);
  localparam logic [BUS_AW-1:0] A_KEY  = BASE + BUS_AW'(OFS_KEY);
  localparam logic [BUS_AW-1:0] A_DATA = BASE + BUS_AW'(OFS_DATA);
  localparam logic [BUS_AW-1:0] A_ADDR = BASE + BUS_AW'(OFS_ADDR);

  logic [7:0]    data_q, addr_q;
  logic          sel_q, wr_en_q, err_q, done_q, rd_go_q;
  logic [IW-1:0] wa_q;
  logic [7:0]    wd_q;

  logic wr_ctrl, wr_key, wr_data, wr_addr;
  logic in_range, armed, busy, tmr_erase, tmr_prog;
  logic rd_req, wr_start;
  logic [7:0] store_q, ctrl_view;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign wr_key  = bus_we && (bus_addr == A_KEY);
  assign wr_data = bus_we && (bus_addr == A_DATA);
  assign wr_addr = bus_we && (bus_addr == A_ADDR);

  assign in_range = (int'(addr_q) < DEPTH);

  assign rd_req   = wr_ctrl && bus_wdata[CB_RD] && !sel_q && in_range;
  assign wr_start = wr_ctrl && bus_wdata[CB_WR] && armed && wr_en_q &&
                    !sel_q && in_range && !busy;

  nvb_keyseq u_key (
    .clk    (clk),
    .rst    (por || warm_rst),
    .wr_any (bus_we),
    .wr_key (wr_key),
    .wdata  (bus_wdata),
    .armed  (armed)
  );

  nvb_wtimer #(.CYCLES(WRITE_CYCLES)) u_tmr (
    .clk   (clk),
    .rst   (por || warm_rst),
    .start (wr_start),
    .busy  (busy),
    .erase (tmr_erase),
    .prog  (tmr_prog)
  );

  nvb_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk   (clk),
    .we    ((tmr_erase || tmr_prog) && !warm_rst && !por),
    .waddr (wa_q),
    .wdata (tmr_prog ? wd_q : ERASED),
    .re    (rd_req),
    .raddr (addr_q[IW-1:0]),
    .rdata (store_q)
  );

  always_ff @(posedge clk) begin
    if (por) begin
      data_q  <= '0;
      addr_q  <= '0;
      sel_q   <= 1'b0;
      wr_en_q <= 1'b0;
      err_q   <= 1'b0;
      done_q  <= 1'b0;
      rd_go_q <= 1'b0;
      wa_q    <= '0;
      wd_q    <= '0;
    end else if (warm_rst) begin
      wr_en_q <= 1'b0;
      done_q  <= 1'b0;
      rd_go_q <= 1'b0;
      if (busy)
        err_q <= 1'b1;
    end else begin
      rd_go_q <= rd_req;
      if (wr_ctrl) begin
        sel_q   <= bus_wdata[CB_SEL];
        wr_en_q <= bus_wdata[CB_WEN];
        err_q   <= err_q && bus_wdata[CB_ERR];
      end
      if (tmr_prog)
        done_q <= 1'b1;
      else if (wr_ctrl)
        done_q <= done_q && bus_wdata[CB_DONE];
      if (rd_go_q)
        data_q <= store_q;
      else if (wr_data && !busy)
        data_q <= bus_wdata;
      if (wr_addr && !busy)
        addr_q <= bus_wdata;
      if (wr_start) begin
        wa_q <= addr_q[IW-1:0];
        wd_q <= data_q;
      end
    end
  end

  always_comb begin
    ctrl_view          = '0;
    ctrl_view[CB_RD]   = rd_go_q;
    ctrl_view[CB_WR]   = busy;
    ctrl_view[CB_WEN]  = wr_en_q;
    ctrl_view[CB_ERR]  = err_q;
    ctrl_view[CB_DONE] = done_q;
    ctrl_view[CB_SEL]  = sel_q;
  end

  always_ff @(posedge clk) begin
    if (por)
      bus_rdata <= '0;
    else if (bus_re) begin
      unique case (bus_addr)
        A_CTRL:  bus_rdata <= ctrl_view;
        A_DATA:  bus_rdata <= data_q;
        A_ADDR:  bus_rdata <= addr_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign irq = done_q;
endmodule

// File: rtl/nvb_ctrl_chk.sv
module nvb_ctrl_chk #(
  parameter int                BUS_AW       = 12,
  parameter logic [BUS_AW-1:0] BASE         = 12'hFA6,
  parameter int                WRITE_CYCLES = 1000
) (
  input logic              clk,
  input logic              por,
  input logic              warm_rst,
  input logic              bus_re,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [7:0]        bus_rdata,
  input logic              busy,
  input logic              tmr_prog,
  input logic              wr_en_q,
  input logic              err_q,
  input logic              irq
);
  int busy_cnt;

  always_ff @(posedge clk) begin
    if (por || warm_rst)
      busy_cnt <= 0;
    else if (busy)
      busy_cnt <= busy_cnt + 1;
    else
      busy_cnt <= 0;
  end

  a_r1_key_reads_zero: assert property (@(posedge clk) disable iff (por)
    bus_re && (bus_addr == BASE + BUS_AW'(1)) |=> bus_rdata == 8'h00);

  a_r5_start_needs_enable: assert property (@(posedge clk) disable iff (por || warm_rst)
    $rose(busy) |-> $past(wr_en_q));

  a_r6_busy_bounded: assert property (@(posedge clk) disable iff (por || warm_rst)
    busy |-> busy_cnt < WRITE_CYCLES);

  a_r6_program_at_end: assert property (@(posedge clk) disable iff (por || warm_rst)
    tmr_prog |-> busy_cnt == WRITE_CYCLES - 1);

  a_r8_irq_after_done: assert property (@(posedge clk) disable iff (por || warm_rst)
    tmr_prog |=> irq);

  a_r11_abort_sets_error: assert property (@(posedge clk) disable iff (por)
    busy && warm_rst |=> err_q);

  a_r11_abort_clears_busy: assert property (@(posedge clk) disable iff (por)
    warm_rst |=> !busy);
endmodule

bind nvb_ctrl nvb_ctrl_chk #(
  .BUS_AW(BUS_AW), .BASE(BASE), .WRITE_CYCLES(WRITE_CYCLES)
) u_chk (
  .clk       (clk),
  .por       (por),
  .warm_rst  (warm_rst),
  .bus_re    (bus_re),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .busy      (busy),
  .tmr_prog  (tmr_prog),
  .wr_en_q   (wr_en_q),
  .err_q     (err_q),
  .irq       (irq)
);

// File: tb/tb_nvb_ctrl.sv
`timescale 1ns/1ps
module tb_nvb_ctrl;
  localparam int W = 5;
  localparam logic [11:0] CTRL = 12'hFA6;
  localparam logic [11:0] KEY  = 12'hFA7;
  localparam logic [11:0] DATA = 12'hFA8;
  localparam logic [11:0] ADDR = 12'hFA9;

  logic        clk = 1'b0;
  logic        por = 1'b1;
  logic        warm_rst = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [7:0]  bus_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  nvb_ctrl #(.WRITE_CYCLES(W)) dut (
    .clk(clk), .por(por), .warm_rst(warm_rst), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] v);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    v = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_write(input logic [7:0] a, input logic [7:0] d);
    wr(ADDR, a); wr(DATA, d); wr(CTRL, 8'h04);
    wr(KEY, 8'h55); wr(KEY, 8'hAA); wr(CTRL, 8'h06);
  endtask

  task automatic mem_read(input logic [7:0] a, output logic [7:0] v);
    wr(ADDR, a); wr(CTRL, 8'h01); idle(1); rd(DATA, v);
  endtask

  logic [7:0] v;

  initial begin
    idle(3);
    por = 1'b0;
    // R12 / R3 / R1: reset state and map
    rd(CTRL, v); chk("R12 ctrl after por", v, 8'h00);
    rd(DATA, v); chk("R12 data after por", v, 8'h00);
    rd(ADDR, v); chk("R12 addr after por", v, 8'h00);
    rd(KEY, v);  chk("R1 key reads zero", v, 8'h00);
    rd(12'hFAA, v); chk("R1 unmapped reads zero", v, 8'h00);
    // R2 readback
    wr(DATA, 8'h3C); rd(DATA, v); chk("R2 data readback", v, 8'h3C);
    wr(ADDR, 8'h15); rd(ADDR, v); chk("R2 addr readback", v, 8'h15);
    wr(KEY, 8'h12); rd(KEY, v); chk("R1 key write reads zero", v, 8'h00);
    // R7 / R4 sweep: program every byte, then read every byte
    for (int i = 0; i < 64; i++) begin
      start_write(8'(i), pat(i));
      idle(W + 1);
    end
    for (int i = 0; i < 64; i++) begin
      mem_read(8'(i), v); chk("R4 R7 sweep readback", v, pat(i));
    end
    rd(CTRL, v); chk("R4 read bit self-clears", v & 8'h01, 8'h00);
    // R6 busy window, R8 done flag
    start_write(8'd5, 8'h5A);
    for (int k = 0; k < W; k++) begin
      rd(CTRL, v); chk("R6 busy held", {7'b0, v[1]}, 8'h01);
    end
    rd(CTRL, v); chk("R6 busy cleared by hw", {7'b0, v[1]}, 8'h00);
    chk("R8 ctrl after completion", v, 8'h14);
    chk("R8 irq high", {7'b0, irq}, 8'h01);
    wr(CTRL, 8'h14); rd(CTRL, v); chk("R8 writing 1 keeps done", v, 8'h14);
    wr(CTRL, 8'h04); rd(CTRL, v); chk("R8 writing 0 clears done", v, 8'h04);
    chk("R8 irq low", {7'b0, irq}, 8'h00);
    mem_read(8'd5, v); chk("R7 new value after write", v, 8'h5A);
    // R7 erase phase visible, R6 zero-writes ignored
    start_write(8'd7, 8'h3E);
    idle(1);
    wr(CTRL, 8'h05);
    idle(1);
    rd(DATA, v); chk("R7 erased during write", v, 8'hFF);
    rd(CTRL, v); chk("R6 zero write leaves busy", {7'b0, v[1]}, 8'h01);
    idle(W);
    mem_read(8'd7, v); chk("R7 programmed after erase", v, 8'h3E);
    // R9 writes ignored while busy
    start_write(8'd9, 8'h66);
    wr(DATA, 8'h77); wr(ADDR, 8'h20);
    rd(DATA, v); chk("R9 data frozen", v, 8'h66);
    rd(ADDR, v); chk("R9 addr frozen", v, 8'h09);
    idle(W);
    mem_read(8'd9, v);  chk("R9 stored value", v, 8'h66);
    mem_read(8'h20, v); chk("R9 other byte untouched", v, pat(32));
    // R5 broken unlock sequences
    wr(ADDR, 8'd10); wr(DATA, 8'h99);
    wr(CTRL, 8'h00); wr(KEY, 8'h55); wr(KEY, 8'hAA); wr(CTRL, 8'h02);
    rd(CTRL, v); chk("R5 no start without enable", {7'b0, v[1]}, 8'h00);
    wr(CTRL, 8'h04); wr(KEY, 8'hAA); wr(KEY, 8'h55); wr(CTRL, 8'h06);
    rd(CTRL, v); chk("R5 no start reversed key", {7'b0, v[1]}, 8'h00);
    wr(KEY, 8'h55); wr(DATA, 8'h99); wr(KEY, 8'hAA); wr(CTRL, 8'h06);
    rd(CTRL, v); chk("R5 no start interrupted key", {7'b0, v[1]}, 8'h00);
    wr(KEY, 8'h55); wr(KEY, 8'hAA); wr(ADDR, 8'd10); wr(CTRL, 8'h06);
    rd(CTRL, v); chk("R5 no start late ctrl", {7'b0, v[1]}, 8'h00);
    idle(W);
    mem_read(8'd10, v); chk("R5 store unchanged", v, pat(10));
    // R10 memory-select and out-of-range
    wr(ADDR, 8'd3); wr(DATA, 8'h42); wr(CTRL, 8'h80); wr(CTRL, 8'h81);
    idle(1);
    rd(DATA, v); chk("R10 select blocks read", v, 8'h42);
    rd(CTRL, v); chk("R3 select bit position", v, 8'h80);
    wr(CTRL, 8'h84); wr(KEY, 8'h55); wr(KEY, 8'hAA); wr(CTRL, 8'h86);
    rd(CTRL, v); chk("R10 select blocks write", {7'b0, v[1]}, 8'h00);
    wr(CTRL, 8'h00);
    mem_read(8'd3, v); chk("R10 store kept under select", v, pat(3));
    wr(ADDR, 8'h43); wr(DATA, 8'h42); wr(CTRL, 8'h01); idle(1);
    rd(DATA, v); chk("R10 range blocks read", v, 8'h42);
    wr(CTRL, 8'h04); wr(KEY, 8'h55); wr(KEY, 8'hAA); wr(CTRL, 8'h06);
    rd(CTRL, v); chk("R10 range blocks write", {7'b0, v[1]}, 8'h00);
    idle(W);
    mem_read(8'd3, v); chk("R10 aliased byte kept", v, pat(3));
    // R11 warm reset mid-write
    start_write(8'd12, 8'hC3);
    idle(2);
    warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
    rd(CTRL, v); chk("R11 ctrl after abort", v, 8'h08);
    rd(DATA, v); chk("R11 data kept", v, 8'hC3);
    rd(ADDR, v); chk("R11 addr kept", v, 8'h0C);
    wr(CTRL, 8'h08); rd(CTRL, v); chk("R11 error sticky on 1", v, 8'h08);
    wr(CTRL, 8'h00); rd(CTRL, v); chk("R11 error cleared by 0", v, 8'h00);
    mem_read(8'd12, v); chk("R11 aborted byte erased", v, 8'hFF);
    wr(CTRL, 8'h80);
    warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
    rd(CTRL, v); chk("R11 select kept", v, 8'h80);
    wr(CTRL, 8'h00);
    start_write(8'd12, 8'hC3); idle(W + 1);
    mem_read(8'd12, v); chk("R11 retry succeeds", v, 8'hC3);
    // R12 power-on reset
    start_write(8'd13, 8'h31);
    idle(2);
    warm_rst = 1'b1; @(negedge clk); warm_rst = 1'b0;
    wr(CTRL, 8'h8C);
    rd(CTRL, v); chk("R12 setup flags", v, 8'h8C);
    por = 1'b1; @(negedge clk); por = 1'b0;
    rd(CTRL, v); chk("R12 ctrl cleared", v, 8'h00);
    rd(DATA, v); chk("R12 data cleared", v, 8'h00);
    rd(ADDR, v); chk("R12 addr cleared", v, 8'h00);
    mem_read(8'd13, v); chk("R12 erased byte survives", v, 8'hFF);
    mem_read(8'd0, v);  chk("R12 store survives", v, pat(0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule